// File: doc/BRIEF.md
# Gate-Driven Acquisition Packetizer

This block takes one of four 12-bit sample streams and, while an acquisition gate is high, packs the samples into 32-bit words for a DMA engine. The length of a transfer is not set in advance. It is simply the number of samples that arrive while the gate is high. The block holds finished words in a small queue and delivers them on a valid/ready stream. Each word carries start-of-packet and end-of-packet markers.

The length is only known once the gate falls. For that reason each packet closes with a two-word metadata trailer. The first trailer word holds the sample-exact start time. The second holds the stream identifier, the sample count, an odd-length flag and a loss flag. Two capture modes are supported. In continuous mode every gate produces a packet. In single-shot mode one packet is taken and the block then waits for an arm pulse.

Top module: `acq_packetizer`

## Requirements
- R1: `src_sel` picks the sample source: 0 = first ADC stream, 1 = second ADC stream, 2 = test generator, 3 = playback loopback. The value present at the first sample of a transfer is reported in bits [29:28] of the closing metadata word.
- R2: A sample is taken only in a cycle where `smp_valid` and `gate` are both high. A transfer begins at the first such sample while the block is idle. It ends at the first cycle in which `gate` is low. Samples that arrive while the trailer is still being queued are not taken.
- R3: Samples are sign-extended from 12 to 16 bits and packed two per word. The earlier sample goes in bits [15:0] and the later sample in bits [31:16].
- R4: If a transfer holds an odd number of samples, the last sample is sent alone in bits [15:0] with bits [31:16] zero, and bit 30 of the metadata word is set.
- R5: A packet is made of its data words, then a word holding the `time_cnt` value of the cycle that took the first sample, then a metadata word laid out as [31] loss, [30] odd, [29:28] source, [27:16] zero, [15:0] sample count. `out_sop` marks the first word of the packet and `out_eop` marks the metadata word.
- R6: A gate pulse during which no sample is taken produces no output.
- R7: After reset `out_valid` is low. A word that is offered stays valid and unchanged until `out_ready` accepts it. No word is lost while the queue has room.
- R8: A data word that finds the 8-entry queue full is dropped, and bit 31 of that packet's metadata word is set. The sample count still includes the dropped samples. Trailer words wait for room and are never dropped.
- R9: With `single_shot` high, once one packet's trailer is queued no new transfer starts until an `arm` pulse. With `single_shot` low, every gate is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Sample source choice |
| adc_a_data | input | 12 | First ADC stream |
| adc_b_data | input | 12 | Second ADC stream |
| test_data | input | 12 | Test generator stream |
| loop_data | input | 12 | Playback loopback stream |
| smp_valid | input | 1 | Sample strobe common to all streams |
| gate | input | 1 | Acquisition gate |
| time_cnt | input | 32 | Free-running sample time base |
| single_shot | input | 1 | 1 = single-shot mode, 0 = continuous |
| arm | input | 1 | Re-arm pulse for single-shot mode |
| out_data | output | 32 | Output word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts word |
| out_sop | output | 1 | First word of packet |
| out_eop | output | 1 | Last (metadata) word of packet |

## Verification
The bench runs the following patterns:
- Gates with back-to-back samples and with sparse strobes. These separate the gate-bounded count from a count of clock cycles.
- Even and odd lengths. These expose padding and odd-flag faults.
- Negative test and loopback values. These reveal a swapped source selection or a missing sign extension.
- A gate with no strobe, and a continuous gate held against a stalled output. These tell an empty transfer apart from a real one, and dropped data from a dropped trailer.
- A single-shot sequence with gates before and after the arm pulse. This distinguishes a held capture from a free-running one.

// File: rtl/acq_pkg.sv
package acq_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAP,
        ST_PAD,
        ST_STAMP,
        ST_META
    } acq_state_e;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [WORD_W-1:0] data;
    } acq_word_t;
endpackage

// File: rtl/acq_src_mux.sv
module acq_src_mux #(
    parameter int SMP_W  = 12,
    parameter int HALF_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [SMP_W-1:0] src0,
    input  logic [SMP_W-1:0] src1,
    input  logic [SMP_W-1:0] src2,
    input  logic [SMP_W-1:0] src3,
    output logic [HALF_W-1:0] smp_ext
);
    localparam int EXT_W = HALF_W - SMP_W;

    logic [SMP_W-1:0] picked;

    always_comb begin
        case (sel)
            2'd0:    picked = src0;
            2'd1:    picked = src1;
            2'd2:    picked = src2;
            default: picked = src3;
        endcase
        smp_ext = {{EXT_W{picked[SMP_W-1]}}, picked};
    end
endmodule

// File: rtl/acq_pack_ctrl.sv
module acq_pack_ctrl
    import acq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [HALF_W-1:0] smp_ext,
    input  logic [SEL_W-1:0]  sel,
    input  logic              gate,
    input  logic [WORD_W-1:0] time_cnt,
    input  logic              single_shot,
    input  logic              arm,
    input  logic              fifo_full,
    output logic              push,
    output acq_word_t         push_word
);
    localparam int ZERO_W = WORD_W - 4 - CNT_W;

    typedef struct packed {
        acq_state_e        st;
        logic [WORD_W-1:0] stamp;
        logic [SEL_W-1:0]  chan;
        logic [CNT_W-1:0]  cnt;
        logic [HALF_W-1:0] held;
        logic              held_v;
        logic              sop_due;
        logic              lost;
        logic              odd;
        logic              spent;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        push      = 1'b0;
        push_word = '0;
        if (arm) ctl_d.spent = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (smp_valid && gate && !(single_shot && ctl_q.spent)) begin
                    ctl_d.st      = ST_CAP;
                    ctl_d.stamp   = time_cnt;
                    ctl_d.chan    = sel;
                    ctl_d.cnt     = CNT_W'(1);
                    ctl_d.held    = smp_ext;
                    ctl_d.held_v  = 1'b1;
                    ctl_d.sop_due = 1'b1;
                    ctl_d.lost    = 1'b0;
                    ctl_d.odd     = 1'b0;
                end
            end
            ST_CAP: begin
                if (!gate) begin
                    ctl_d.st = ctl_q.held_v ? ST_PAD : ST_STAMP;
                end else if (smp_valid) begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    if (ctl_q.held_v) begin
                        ctl_d.held_v = 1'b0;
                        if (fifo_full) begin
                            ctl_d.lost = 1'b1;
                        end else begin
                            push          = 1'b1;
                            push_word.sop  = ctl_q.sop_due;
                            push_word.data = {smp_ext, ctl_q.held};
                            ctl_d.sop_due  = 1'b0;
                        end
                    end else begin
                        ctl_d.held   = smp_ext;
                        ctl_d.held_v = 1'b1;
                    end
                end
            end
            ST_PAD: begin
                if (!fifo_full) begin
                    push           = 1'b1;
                    push_word.sop  = ctl_q.sop_due;
                    push_word.data = {{HALF_W{1'b0}}, ctl_q.held};
                    ctl_d.sop_due  = 1'b0;
                    ctl_d.held_v   = 1'b0;
                    ctl_d.odd      = 1'b1;
                    ctl_d.st       = ST_STAMP;
                end
            end
            ST_STAMP: begin
                if (!fifo_full) begin
                    push           = 1'b1;
                    push_word.sop  = ctl_q.sop_due;
                    push_word.data = ctl_q.stamp;
                    ctl_d.sop_due  = 1'b0;
                    ctl_d.st       = ST_META;
                end
            end
            ST_META: begin
                if (!fifo_full) begin
                    push           = 1'b1;
                    push_word.eop  = 1'b1;
                    push_word.data = {ctl_q.lost, ctl_q.odd, ctl_q.chan,
                                      {ZERO_W{1'b0}}, ctl_q.cnt};
                    ctl_d.st       = ST_IDLE;
                    if (single_shot) ctl_d.spent = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    acq_state_e       st_now;
    logic [WORD_W-1:0] stamp_now;
    logic              spent_now;
    assign st_now    = ctl_q.st;
    assign stamp_now = ctl_q.stamp;
    assign spent_now = ctl_q.spent;

    // R5
    stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_now == ST_CAP && $past(st_now) == ST_CAP) |-> $stable(stamp_now));

    // R2
    no_gate_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_now == ST_IDLE && !gate) |=> (st_now == ST_IDLE));

    // R9
    shot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_now == ST_IDLE && spent_now && single_shot && !arm) |=> (st_now == ST_IDLE));
endmodule

// File: rtl/acq_word_fifo.sv
module acq_word_fifo
    import acq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  acq_word_t din,
    input  logic      pop,
    output acq_word_t head,
    output logic      empty,
    output logic      full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t      ptr_d, ptr_q;
    acq_word_t store [DEPTH];
    logic      do_pop;

    assign empty  = (ptr_q.cnt == '0);
    assign full   = (ptr_q.cnt == CW'(DEPTH));
    assign head   = store[ptr_q.rp];
    assign do_pop = pop && !empty;

    always_comb begin
        ptr_d = ptr_q;
        if (push) ptr_d.wp = (ptr_q.wp == AW'(DEPTH - 1)) ? '0 : ptr_q.wp + AW'(1);
        if (do_pop) ptr_d.rp = (ptr_q.rp == AW'(DEPTH - 1)) ? '0 : ptr_q.rp + AW'(1);
        case ({push, do_pop})
            2'b10:   ptr_d.cnt = ptr_q.cnt + CW'(1);
            2'b01:   ptr_d.cnt = ptr_q.cnt - CW'(1);
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push) store[ptr_q.wp] <= din;
    end

    // R8
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !pop) |=> (!empty && $stable(head)));
endmodule

// File: rtl/acq_packetizer.sv
module acq_packetizer
    import acq_pkg::*;
#(
    parameter int SMP_W   = 12,
    parameter int CNT_W   = 16,
    parameter int Q_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_sel,
    input  logic [SMP_W-1:0]  adc_a_data,
    input  logic [SMP_W-1:0]  adc_b_data,
    input  logic [SMP_W-1:0]  test_data,
    input  logic [SMP_W-1:0]  loop_data,
    input  logic              smp_valid,
    input  logic              gate,
    input  logic [WORD_W-1:0] time_cnt,
    input  logic              single_shot,
    input  logic              arm,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop
);
    logic [HALF_W-1:0] smp_ext;
    logic              push;
    acq_word_t         push_word;
    acq_word_t         head;
    logic              q_empty;
    logic              q_full;

    acq_src_mux #(.SMP_W(SMP_W), .HALF_W(HALF_W), .SEL_W(2)) u_mux (
        .sel     (src_sel),
        .src0    (adc_a_data),
        .src1    (adc_b_data),
        .src2    (test_data),
        .src3    (loop_data),
        .smp_ext (smp_ext)
    );

    acq_pack_ctrl #(.CNT_W(CNT_W), .SEL_W(2)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .smp_ext     (smp_ext),
        .sel         (src_sel),
        .gate        (gate),
        .time_cnt    (time_cnt),
        .single_shot (single_shot),
        .arm         (arm),
        .fifo_full   (q_full),
        .push        (push),
        .push_word   (push_word)
    );

    acq_word_fifo #(.DEPTH(Q_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (push_word),
        .pop   (out_ready),
        .head  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    assign out_valid = !q_empty;
    assign out_data  = head.data;
    assign out_sop   = head.sop;
    assign out_eop   = head.eop;
endmodule

// File: tb/tb_acq_packetizer.sv
module tb_acq_packetizer;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'd0;
    logic [11:0] adc_a_data = '0, adc_b_data = '0, test_data = '0, loop_data = '0;
    logic        smp_valid = 1'b0, gate = 1'b0, single_shot = 1'b0, arm = 1'b0;
    logic [31:0] time_cnt = 32'd100;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_valid, out_sop, out_eop;

    acq_packetizer dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .adc_a_data(adc_a_data), .adc_b_data(adc_b_data),
        .test_data(test_data), .loop_data(loop_data),
        .smp_valid(smp_valid), .gate(gate), .time_cnt(time_cnt),
        .single_shot(single_shot), .arm(arm),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    always #10 clk = ~clk;

    int compared = 0, mismatched = 0;
    string tag = "reset";
    int ready_mode = 0;
    int rtick = 0;

    always @(negedge clk) begin
        time_cnt <= time_cnt + 32'd1;
        rtick    <= rtick + 1;
        case (ready_mode)
            0: out_ready <= 1'b1;
            1: out_ready <= (rtick % 3) != 0;
            default: out_ready <= 1'b0;
        endcase
    end

    function automatic logic [15:0] ext12(logic [11:0] d);
        int v = d;
        if (d[11]) v = v - 4096;
        return v[15:0];
    endfunction

    // behavioural reference
    logic [33:0] mq[$];
    int          mst = 0;
    logic [31:0] mts;
    int          mch, mcnt;
    logic [15:0] mheld;
    bit          mheld_v, msop, mlost, modd, mspent;

    always @(posedge clk) begin
        int          sz;
        bit          room, want;
        logic [33:0] pw;
        logic [11:0] raw;
        if (!rst_n) begin
            mq.delete(); mst = 0; mspent = 0; mheld_v = 0;
        end else begin
            sz = mq.size();
            room = sz < DEPTH;
            want = 0;
            pw = '0;
            raw = (src_sel == 0) ? adc_a_data : (src_sel == 1) ? adc_b_data :
                  (src_sel == 2) ? test_data : loop_data;
            if (arm) mspent = 0;
            if (mst == 0) begin
                if (smp_valid && gate && !(single_shot && mspent)) begin
                    mst = 1; mts = time_cnt; mch = src_sel; mcnt = 1;
                    mheld = ext12(raw); mheld_v = 1; msop = 1; mlost = 0; modd = 0;
                end
            end else if (mst == 1) begin
                if (!gate) mst = mheld_v ? 2 : 3;
                else if (smp_valid) begin
                    mcnt++;
                    if (!mheld_v) begin
                        mheld = ext12(raw); mheld_v = 1;
                    end else begin
                        mheld_v = 0;
                        if (!room) mlost = 1;
                        else begin
                            want = 1; pw = {msop, 1'b0, ext12(raw), mheld}; msop = 0;
                        end
                    end
                end
            end else if (room) begin
                want = 1;
                if (mst == 2) begin
                    pw = {msop, 1'b0, 16'h0, mheld}; msop = 0; mheld_v = 0; modd = 1; mst = 3;
                end else if (mst == 3) begin
                    pw = {msop, 1'b0, mts}; msop = 0; mst = 4;
                end else begin
                    pw = {1'b0, 1'b1, mlost, modd, mch[1:0], 12'h0, mcnt[15:0]};
                    mst = 0;
                    if (single_shot) mspent = 1;
                end
            end
            if (sz > 0 && out_ready) void'(mq.pop_front());
            if (want) mq.push_back(pw);
        end
    end

    // per-cycle comparison and handshake capture
    logic        seen_v;
    logic [33:0] seen_w;
    always @(negedge clk) begin
        seen_v = out_valid;
        seen_w = {out_sop, out_eop, out_data};
        if (rst_n) begin
            compared++;
            if (out_valid !== (mq.size() > 0) ||
                (out_valid && seen_w !== mq[0])) begin
                mismatched++;
                $display("FAIL %s: valid=%b word=%h expected valid=%b word=%h", tag,
                         out_valid, seen_w, mq.size() > 0,
                         (mq.size() > 0) ? mq[0] : 34'h0);
            end
        end
    end

    int          eop_seen = 0;
    logic [31:0] last_meta, last_stamp, prev_word;
    always @(posedge clk) begin
        if (rst_n && seen_v && out_ready) begin
            if (seen_w[32]) begin
                eop_seen++;
                last_meta  = seen_w[31:0];
                last_stamp = prev_word;
            end
            prev_word = seen_w[31:0];
        end
    end

    task automatic check(bit ok, string t, longint act, longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
        adc_a_data = 12'($urandom); adc_b_data = 12'($urandom);
        test_data  = 12'($urandom) | 12'h800; loop_data = 12'($urandom) | 12'h800;
    endtask

    logic [31:0] first_ts;

    task automatic drain();
        for (int i = 0; i < 400 && (mst != 0 || mq.size() != 0); i++) step();
        step(); step();
    endtask

    task automatic run_gate(int nsmp, int gap, int rmode_during);
        int got = 0;
        ready_mode = rmode_during;
        step();
        gate = 1;
        while (got < nsmp) begin
            smp_valid = 1;
            if (got == 0) first_ts = time_cnt;
            got++;
            step();
            for (int g = 0; g < gap; g++) begin
                smp_valid = 0;
                step();
            end
        end
        smp_valid = 0; gate = 0;
        step();
        ready_mode = 0;
        drain();
    endtask

    initial begin
        int e0;
        for (int i = 0; i < 150000; i++) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int e0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7 reset valid", out_valid, 0);
        step(); rst_n = 1; step();

        tag = "R3"; src_sel = 0;
        run_gate(6, 0, 0);
        check(last_meta[15:0] == 6, "R3 count", last_meta[15:0], 6);
        check(last_stamp == first_ts, "R5 stamp", last_stamp, first_ts);

        tag = "R4"; src_sel = 1;
        run_gate(5, 0, 0);
        check(last_meta[30] == 1'b1, "R4 odd flag", last_meta[30], 1);
        check(last_meta[29:28] == 2'd1, "R1 chan b", last_meta[29:28], 1);

        tag = "R1"; src_sel = 2;
        run_gate(4, 0, 0);
        check(last_meta[29:28] == 2'd2, "R1 chan test", last_meta[29:28], 2);
        src_sel = 3;
        run_gate(3, 0, 0);
        check(last_meta[29:28] == 2'd3, "R1 chan loop", last_meta[29:28], 3);

        tag = "R2"; src_sel = 0;
        run_gate(7, 2, 0);
        check(last_meta[15:0] == 7, "R2 sparse count", last_meta[15:0], 7);
        check(last_stamp == first_ts, "R5 sparse stamp", last_stamp, first_ts);

        tag = "R6";
        e0 = eop_seen;
        step(); gate = 1;
        for (int i = 0; i < 5; i++) step();
        gate = 0; step();
        drain();
        check(eop_seen == e0, "R6 empty gate", eop_seen, e0);

        tag = "R7";
        run_gate(9, 1, 1);
        check(last_meta[15:0] == 9 && !last_meta[31], "R7 stalled no loss",
              last_meta, 9);

        tag = "R8";
        run_gate(30, 0, 2);
        check(last_meta[31] == 1'b1, "R8 loss flag", last_meta[31], 1);
        check(last_meta[15:0] == 30, "R8 count", last_meta[15:0], 30);

        tag = "R9"; single_shot = 1;
        e0 = eop_seen;
        run_gate(4, 0, 0);
        run_gate(4, 0, 0);
        check(eop_seen == e0 + 1, "R9 held after shot", eop_seen, e0 + 1);
        step(); arm = 1; step(); arm = 0;
        run_gate(2, 0, 0);
        check(eop_seen == e0 + 2, "R9 after arm", eop_seen, e0 + 2);
        single_shot = 0;
        run_gate(2, 0, 0);
        run_gate(2, 0, 0);
        check(eop_seen == e0 + 4, "R9 continuous", eop_seen, e0 + 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule